// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces memory addresses for a single data-memory port of a signal processor. It keeps eight groups of 32-bit pointer registers: an index, a step, a window base and a window length. Each access names one index register and one step source. The index is the address, and afterwards the index moves by the step. The step comes from a step register or from an immediate offset carried with the access.

When the selected window length is nonzero, an index that leaves the window is folded back into it. This gives circular buffers that work for both positive and negative steps. A mode input turns on bit-reversed output: the low N bits of the outgoing address are mirrored, which gives the scrambled ordering that radix-2 FFT passes need. The stored index still advances linearly.

A pre-modify option sends out the stepped address and leaves the index unchanged. Software loads and inspects every register through a plain write-enable port and a combinational read port.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every index, step, base and length register reads 0, `addr_out` is 0 and `addr_vld` is 0.
- R2: A write with `wr_sel` = 0 (index), 1 (step), 2 (base) or 3 (length) stores `wr_data` into entry `wr_idx` of that group. The value is visible on `rd_data` (selected by `rd_sel`/`rd_idx` with the same encoding) from the cycle after the write.
- R3: Writing an index register with `wr_base` = 1 also loads the base register of the same entry with the same value. With `wr_base` = 0 the base register is left unchanged.
- R4: In post-modify mode (`acc_pre` = 0), an access presented in one cycle drives `addr_out` with the old index and `addr_vld` = 1 in the next cycle. The index is replaced by its stepped value.
- R5: With `acc_use_imm` = 1 the step is `acc_imm`, taken as a signed value, instead of the step register named by `acc_m`.
- R6: With a nonzero length L and base B, a stepped value at or above B+L is reduced by L.
- R7: With a nonzero length, a stepped value below B (negative step) is raised by L.
- R8: With a length of zero the step is plain addition modulo 2^32.
- R9: In pre-modify mode (`acc_pre` = 1) the address is the stepped and window-folded value, and the index register is not changed.
- R10: With `bitrev_en` = 1 the low N bits of the address are mirrored (bit k takes bit N-1-k) and the upper bits pass through unchanged. N is `bitrev_bits`; N = 0 means no change, and N above 32 acts as 32. The stored index is never mirrored.
- R11: If a register write targets the same index register that an access updates in the same cycle, the write wins. The access still uses the old index for its address.
- R12: In a cycle with no access, `addr_vld` is 0 in the next cycle and `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register group to write (0 index, 1 step, 2 base, 3 length) |
| wr_idx | input | 3 | Entry to write |
| wr_data | input | 32 | Write value |
| wr_base | input | 1 | An index write also loads the base |
| rd_sel | input | 2 | Register group to read |
| rd_idx | input | 3 | Entry to read |
| rd_data | output | 32 | Read value (combinational) |
| acc_en | input | 1 | Access request |
| acc_i | input | 3 | Index register used by the access |
| acc_m | input | 3 | Step register used by the access |
| acc_use_imm | input | 1 | Use the immediate step |
| acc_imm | input | 32 | Signed immediate step |
| acc_pre | input | 1 | Pre-modify: output the stepped value, keep the index |
| bitrev_en | input | 1 | Mode bit for bit-reversed output |
| bitrev_bits | input | 6 | Number of low address bits to mirror |
| addr_out | output | 32 | Generated address |
| addr_vld | output | 1 | Address produced by the previous cycle's access |

## Verification
The bench aims at the edges of the circular window. A step that lands exactly on B+L must fold to B, and a negative step that drops below B must fold up. An off-by-one in either compare would leave the pointer one past the window or fold it one step early.

Linear wrap past 2^32 with a zero length is checked, because a design that folds whenever L is zero would produce a garbage pointer. Bit reversal is checked for a narrow width with upper bits set, for a zero width and for a width above 32. These catch a design that mirrors the whole word or indexes out of range.

Two further cases are covered. A write and an access that hit the same index in one cycle catch a wrong priority, which would lose the software load. A pre-modify access catches a design that wrongly advances the index.

// File: rtl/cag_pkg.sv
package cag_pkg;
    typedef enum logic [1:0] {
        SEL_IDX  = 2'd0,
        SEL_STEP = 2'd1,
        SEL_BASE = 2'd2,
        SEL_LEN  = 2'd3
    } cag_sel_e;
endpackage

// File: rtl/cag_regbank.sv
module cag_regbank
    import cag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          wr_base,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic [AW-1:0] upd_val,
    input  logic [1:0]    rd_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    input  logic [IW-1:0] acc_i,
    input  logic [IW-1:0] acc_m,
    output logic [AW-1:0] i_val,
    output logic [AW-1:0] m_val,
    output logic [AW-1:0] b_val,
    output logic [AW-1:0] l_val
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:0] idx;
        logic [NREG-1:0][AW-1:0] step;
        logic [NREG-1:0][AW-1:0] base;
        logic [NREG-1:0][AW-1:0] len;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // index update from an access first, so a software write overrides it
        if (upd_en) begin
            bank_d.idx[upd_idx] = upd_val;
        end
        if (wr_en) begin
            unique case (cag_sel_e'(wr_sel))
                SEL_IDX: begin
                    bank_d.idx[wr_idx] = wr_data;
                    if (wr_base) begin
                        bank_d.base[wr_idx] = wr_data;
                    end
                end
                SEL_STEP: bank_d.step[wr_idx] = wr_data;
                SEL_BASE: bank_d.base[wr_idx] = wr_data;
                SEL_LEN:  bank_d.len[wr_idx]  = wr_data;
                default:  bank_d.len[wr_idx]  = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        unique case (cag_sel_e'(rd_sel))
            SEL_IDX:  rd_data = bank_q.idx[rd_idx];
            SEL_STEP: rd_data = bank_q.step[rd_idx];
            SEL_BASE: rd_data = bank_q.base[rd_idx];
            SEL_LEN:  rd_data = bank_q.len[rd_idx];
            default:  rd_data = bank_q.len[rd_idx];
        endcase
    end

    assign i_val = bank_q.idx[acc_i];
    assign m_val = bank_q.step[acc_m];
    assign b_val = bank_q.base[acc_i];
    assign l_val = bank_q.len[acc_i];
endmodule

// File: rtl/cag_modulo.sv
module cag_modulo #(
    parameter int AW  = 32,
    localparam int EW = AW + 2
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    logic signed [EW-1:0] sum_e, lo_e, hi_e, len_e, fold_e;

    always_comb begin
        sum_e  = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        lo_e   = $signed({2'b00, base});
        len_e  = $signed({2'b00, len});
        hi_e   = lo_e + len_e;
        fold_e = sum_e;
        if (len != '0) begin
            if (sum_e >= hi_e) begin
                fold_e = sum_e - len_e;
            end else if (sum_e < lo_e) begin
                fold_e = sum_e + len_e;
            end
        end
        nxt = fold_e[AW-1:0];
    end
endmodule

// File: rtl/cag_bitrev.sv
module cag_bitrev #(
    parameter int AW  = 32,
    localparam int NW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] din,
    input  logic [NW-1:0] nbits,
    output logic [AW-1:0] dout
);
    int width;

    always_comb begin
        width = (int'(nbits) > AW) ? AW : int'(nbits);
        dout  = din;
        for (int k = 0; k < AW; k++) begin
            if (k < width) begin
                dout[k] = din[width - 1 - k];
            end
        end
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG),
    localparam int NW  = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          wr_base,
    input  logic [1:0]    rd_sel,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_i,
    input  logic [IW-1:0] acc_m,
    input  logic          acc_use_imm,
    input  logic [AW-1:0] acc_imm,
    input  logic          acc_pre,
    input  logic          bitrev_en,
    input  logic [NW-1:0] bitrev_bits,
    output logic [AW-1:0] addr_out,
    output logic          addr_vld
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          vld;
    } out_t;

    out_t out_d, out_q;

    logic [AW-1:0] i_val, m_val, b_val, l_val;
    logic [AW-1:0] step_sel, stepped, raw_addr, rev_addr;
    logic          upd_en;

    cag_regbank #(.AW(AW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_base (wr_base),
        .upd_en  (upd_en),
        .upd_idx (acc_i),
        .upd_val (stepped),
        .rd_sel  (rd_sel),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .acc_i   (acc_i),
        .acc_m   (acc_m),
        .i_val   (i_val),
        .m_val   (m_val),
        .b_val   (b_val),
        .l_val   (l_val)
    );

    assign step_sel = acc_use_imm ? acc_imm : m_val;

    cag_modulo #(.AW(AW)) u_mod (
        .cur  (i_val),
        .step (step_sel),
        .base (b_val),
        .len  (l_val),
        .nxt  (stepped)
    );

    assign raw_addr = acc_pre ? stepped : i_val;
    assign upd_en   = acc_en && !acc_pre;

    cag_bitrev #(.AW(AW)) u_rev (
        .din   (raw_addr),
        .nbits (bitrev_bits),
        .dout  (rev_addr)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = acc_en;
        if (acc_en) begin
            out_d.addr = bitrev_en ? rev_addr : raw_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_out = out_q.addr;
    assign addr_vld = out_q.vld;
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic [IW-1:0] wr_idx,
    input logic [AW-1:0] wr_data,
    input logic          wr_base,
    input logic [1:0]    rd_sel,
    input logic [IW-1:0] rd_idx,
    input logic [AW-1:0] rd_data,
    input logic          acc_en,
    input logic [IW-1:0] acc_i,
    input logic          acc_pre,
    input logic          bitrev_en,
    input logic [AW-1:0] addr_out,
    input logic          addr_vld
);
    assert_vld_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_vld);

    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (!addr_vld && $stable(addr_out)));

    assert_post_old_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_pre && !bitrev_en && rd_sel == 2'd0 && rd_idx == acc_i)
        |=> addr_out == $past(rd_data));

    assert_pre_keeps_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_pre && !wr_en && rd_sel == 2'd0 && rd_idx == acc_i)
        |=> (!(rd_sel == 2'd0 && rd_idx == $past(rd_idx)) || rd_data == $past(rd_data)));

    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!(rd_sel == $past(wr_sel) && rd_idx == $past(wr_idx))
                   || rd_data == $past(wr_data)));

    assert_base_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_base)
        |=> (!(rd_sel == 2'd2 && rd_idx == $past(wr_idx)) || rd_data == $past(wr_data)));
endmodule

bind circ_addr_gen cag_checker #(.AW(AW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_base   (wr_base),
    .rd_sel    (rd_sel),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .acc_en    (acc_en),
    .acc_i     (acc_i),
    .acc_pre   (acc_pre),
    .bitrev_en (bitrev_en),
    .addr_out  (addr_out),
    .addr_vld  (addr_vld)
);

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        wr_base = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        acc_en = 1'b0;
    logic [2:0]  acc_i = '0;
    logic [2:0]  acc_m = '0;
    logic        acc_use_imm = 1'b0;
    logic [31:0] acc_imm = '0;
    logic        acc_pre = 1'b0;
    logic        bitrev_en = 1'b0;
    logic [5:0]  bitrev_bits = '0;
    logic [31:0] addr_out;
    logic        addr_vld;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    circ_addr_gen u_circ_addr_gen (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] i, input logic [31:0] d,
                      input logic b);
        wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d; wr_base = b;
        tick();
        wr_en = 1'b0; wr_base = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] s, input logic [2:0] i,
                          input logic [31:0] exp);
        rd_sel = s; rd_idx = i;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic access(input logic [2:0] i, input logic [2:0] m, input logic imm,
                          input logic [31:0] immv, input logic pre);
        acc_en = 1'b1; acc_i = i; acc_m = m; acc_use_imm = imm; acc_imm = immv;
        acc_pre = pre;
        tick();
        acc_en = 1'b0; acc_use_imm = 1'b0; acc_pre = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addr_out", addr_out, 32'd0);
        chk("R1 addr_vld", {31'd0, addr_vld}, 32'd0);
        for (int g = 0; g < 4; g++) begin
            rd_chk("R1 reg", 2'(g), 3'd5, 32'd0);
        end
    endtask

    task automatic t_regs();
        wr(2'd1, 3'd3, 32'd5, 1'b0);
        rd_chk("R2 step write", 2'd1, 3'd3, 32'd5);
        wr(2'd3, 3'd6, 32'h0000_0040, 1'b0);
        rd_chk("R2 length write", 2'd3, 3'd6, 32'h0000_0040);
        wr(2'd0, 3'd1, 32'd100, 1'b1);
        rd_chk("R3 base loaded", 2'd2, 3'd1, 32'd100);
        wr(2'd0, 3'd2, 32'd7, 1'b0);
        rd_chk("R3 base untouched", 2'd2, 3'd2, 32'd0);
        rd_chk("R2 index write", 2'd0, 3'd2, 32'd7);
    endtask

    task automatic t_linear();
        wr(2'd0, 3'd0, 32'd10, 1'b0);
        wr(2'd1, 3'd0, 32'd3, 1'b0);
        access(3'd0, 3'd0, 1'b0, '0, 1'b0);
        chk("R4 addr", addr_out, 32'd10);
        chk("R4 vld", {31'd0, addr_vld}, 32'd1);
        rd_chk("R4 index stepped", 2'd0, 3'd0, 32'd13);
        access(3'd0, 3'd0, 1'b1, 32'hFFFF_FFFC, 1'b0);
        chk("R5 addr", addr_out, 32'd13);
        rd_chk("R5 imm step", 2'd0, 3'd0, 32'd9);
        tick();
        chk("R12 vld low", {31'd0, addr_vld}, 32'd0);
        chk("R12 addr held", addr_out, 32'd13);
        wr(2'd0, 3'd3, 32'hFFFF_FFFE, 1'b0);
        access(3'd3, 3'd0, 1'b1, 32'd4, 1'b0);
        rd_chk("R8 linear wrap", 2'd0, 3'd3, 32'd2);
    endtask

    task automatic t_circular();
        wr(2'd3, 3'd1, 32'd8, 1'b0);
        wr(2'd0, 3'd1, 32'd106, 1'b0);
        wr(2'd1, 3'd1, 32'd3, 1'b0);
        access(3'd1, 3'd1, 1'b0, '0, 1'b0);
        chk("R6 addr", addr_out, 32'd106);
        rd_chk("R6 fold down", 2'd0, 3'd1, 32'd101);
        wr(2'd1, 3'd2, 32'hFFFF_FFFD, 1'b0);
        access(3'd1, 3'd2, 1'b0, '0, 1'b0);
        chk("R7 addr", addr_out, 32'd101);
        rd_chk("R7 fold up", 2'd0, 3'd1, 32'd106);
        access(3'd1, 3'd1, 1'b0, '0, 1'b1);
        chk("R9 pre addr", addr_out, 32'd101);
        rd_chk("R9 index kept", 2'd0, 3'd1, 32'd106);
        access(3'd1, 3'd0, 1'b1, 32'd2, 1'b0);
        rd_chk("R6 exact end folds to base", 2'd0, 3'd1, 32'd100);
    endtask

    task automatic t_bitrev();
        wr(2'd0, 3'd4, 32'd1, 1'b0);
        wr(2'd1, 3'd4, 32'd1, 1'b0);
        bitrev_en = 1'b1; bitrev_bits = 6'd10;
        access(3'd4, 3'd4, 1'b0, '0, 1'b0);
        chk("R10 rev 1", addr_out, 32'h0000_0200);
        rd_chk("R10 index linear", 2'd0, 3'd4, 32'd2);
        access(3'd4, 3'd4, 1'b0, '0, 1'b0);
        chk("R10 rev 2", addr_out, 32'h0000_0100);
        wr(2'd0, 3'd5, 32'h1234_5001, 1'b0);
        bitrev_bits = 6'd4;
        access(3'd5, 3'd4, 1'b0, '0, 1'b0);
        chk("R10 upper kept", addr_out, 32'h1234_5008);
        bitrev_bits = 6'd0;
        access(3'd5, 3'd4, 1'b0, '0, 1'b0);
        chk("R10 zero width", addr_out, 32'h1234_5002);
        wr(2'd0, 3'd7, 32'd1, 1'b0);
        bitrev_bits = 6'd40;
        access(3'd7, 3'd4, 1'b0, '0, 1'b0);
        chk("R10 clamp 32", addr_out, 32'h8000_0000);
        bitrev_en = 1'b0; bitrev_bits = 6'd0;
    endtask

    task automatic t_collide();
        wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 3'd0; wr_data = 32'd500;
        acc_en = 1'b1; acc_i = 3'd0; acc_m = 3'd0;
        tick();
        wr_en = 1'b0; acc_en = 1'b0;
        chk("R11 old index used", addr_out, 32'd9);
        rd_chk("R11 write wins", 2'd0, 3'd0, 32'd500);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_regs();
        t_linear();
        t_circular();
        t_bitrev();
        t_collide();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule